// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into stored characters. It runs on the system clock and moves forward only on a one-cycle enable that pulses sixteen times per bit period. The line first passes through a multi-flop synchronizer. A falling edge starts a candidate start bit, and the line is checked again at the middle of that bit. If the start bit is valid, the receiver takes one sample per bit period at the bit centre. It collects five to eight data bits, least significant bit first, then an optional parity bit, then one stop bit.

Each finished character goes into a three-entry holding queue. The character is stored with its own parity-error, framing-error and break flags. Software sees the head of the queue through a ready flag and a full flag, and removes the head with a read strobe. A character that arrives while the queue is full is dropped. When that happens, a sticky overrun flag is set and the request-to-send output is pulled low. Software raises request-to-send with a one-cycle command.

Two line conditions get special handling. A long low after a bad stop bit becomes the start of the next character. A break needs the line to go idle before the receiver searches for a new start bit.

Top module: `uartRx`

## Requirements
- R1: After a falling edge on `rxd`, the receiver samples the line once, eight ticks later. If the line is high at that point, the start bit is rejected: nothing is stored and the edge search resumes.
- R2: Data bits are sampled at bit centres, least significant bit first. `charLen` selects 5, 6, 7 or 8 data bits for codes 0 to 3. For lengths below eight, `rxData` bits above the character length read 0.
- R3: `parMode` selects the parity bit that follows the data: 0 none, 1 even, 2 odd, 3 forced 0, 4 forced 1. `parityErr` is set on a stored character when the total count of ones (even/odd) or the received bit (forced) does not match the selected mode.
- R4: When the stop bit is high, the character is stored without a framing error, and the very next falling edge is accepted as a new start bit, with no idle time needed.
- R5: A low stop bit after non-zero data stores the character with `frameErr` set. If the line is still low half a bit time after that stop sample, the next character is received with no further start edge. If the line is high at that point, the receiver goes back to idle.
- R6: When the data, parity and stop bits are all low, the receiver stores a character of 0 with `breakFlag` set and `parityErr` and `frameErr` clear. No start search begins until the line has been high for eight ticks in a row.
- R7: The queue holds up to three characters and returns them in arrival order. `rxReady` is high while the queue holds at least one character, and `fifoFull` is high while it holds three. `readStrobe` removes the head; it has no effect on an empty queue.
- R8: A character that completes while the queue is full is discarded and sets `overrunFlag`. The flag stays set until `clearErr` is pulsed.
- R9: `rtsOut` goes high one cycle after a `rtsSet` pulse, and goes low in the same cycle that an overrun occurs.
- R10: After reset, the queue is empty, all flags are low, `rtsOut` is low and the receiver is waiting for a start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, sixteen pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| charLen | input | 2 | Data length code, 5 + value bits |
| parMode | input | 3 | Parity mode code (see R3) |
| readStrobe | input | 1 | Remove head character |
| clearErr | input | 1 | Clear the sticky overrun flag |
| rtsSet | input | 1 | Raise request-to-send |
| rxData | output | 8 | Head character |
| rxReady | output | 1 | Queue not empty |
| fifoFull | output | 1 | Queue holds three characters |
| parityErr | output | 1 | Head character parity error |
| frameErr | output | 1 | Head character framing error |
| breakFlag | output | 1 | Head character is a break |
| overrunFlag | output | 1 | Sticky overrun |
| rtsOut | output | 1 | Request-to-send |

## Verification
The bench uses the default parameters: sixteen ticks per bit, a three-entry queue and a two-stage synchronizer. It holds `tick16` high on every clock, so one bit lasts sixteen clocks. With this setting, four back-to-back frames are enough to fill the queue and cause an overrun within a few hundred cycles. The sixteen-clock bit also lets the bench put line edges a few clocks from a sample point, which tests the half-bit start check, the framing-error restart and the idle wait after a break at their timing limits.

// File: rtl/uartRxPkg.sv
package uartRxPkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_EVEN = 3'd1,
    PAR_ODD  = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } parMode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearChar;
    logic sampleData;
    logic sampleParity;
    logic pushChar;
    logic markFrame;
    logic markBreak;
  } rxStrobe_t;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              parErr;
    logic              frmErr;
    logic              brk;
  } rxEntry_t;

endpackage

// File: rtl/uartRxCtrl.sv
module uartRxCtrl
  import uartRxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int CNT_W      = $clog2(OVERSAMPLE)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxSync,
  input  logic [1:0] charLen,
  input  logic       parEnable,
  input  logic       dataNonZero,
  input  logic       charAllLow,
  output rxStrobe_t  strobe,
  output logic [2:0] bitIdx
);

  localparam logic [CNT_W-1:0] LAST      = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PARITY, S_STOP, S_FEWAIT, S_BRKWAIT
  } state_e;

  state_e           state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic [2:0]       nextBit;
  logic             prevRx;
  logic [2:0]       lastBit;

  assign lastBit = {1'b0, charLen} + 3'd4;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    nextBit   = bitIdx;
    strobe    = '0;
    if (tick) begin
      unique case (state)
        S_IDLE: begin
          if (prevRx && !rxSync) begin
            nextState = S_START;
            nextCnt   = '0;
          end
        end
        S_START: begin
          if (cnt == HALF_LAST) begin
            if (rxSync) begin
              nextState = S_IDLE;
            end else begin
              nextState        = S_DATA;
              nextCnt          = '0;
              nextBit          = '0;
              strobe.clearChar = 1'b1;
            end
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt == LAST) begin
            strobe.sampleData = 1'b1;
            nextCnt           = '0;
            if (bitIdx == lastBit) begin
              nextState = parEnable ? S_PARITY : S_STOP;
            end else begin
              nextBit = bitIdx + 3'd1;
            end
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
        S_PARITY: begin
          if (cnt == LAST) begin
            strobe.sampleParity = 1'b1;
            nextCnt             = '0;
            nextState           = S_STOP;
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt == LAST) begin
            strobe.pushChar = 1'b1;
            nextCnt         = '0;
            if (rxSync) begin
              nextState = S_IDLE;
            end else if (charAllLow) begin
              strobe.markBreak = 1'b1;
              nextState        = S_BRKWAIT;
            end else begin
              strobe.markFrame = 1'b1;
              nextState        = dataNonZero ? S_FEWAIT : S_IDLE;
            end
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
        S_FEWAIT: begin
          if (cnt == HALF_LAST) begin
            if (!rxSync) begin
              nextState        = S_DATA;
              nextCnt          = '0;
              nextBit          = '0;
              strobe.clearChar = 1'b1;
            end else begin
              nextState = S_IDLE;
            end
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
        S_BRKWAIT: begin
          if (!rxSync) begin
            nextCnt = '0;
          end else if (cnt == HALF_LAST) begin
            nextState = S_IDLE;
            nextCnt   = '0;
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      prevRx <= 1'b1;
    end else begin
      state  <= nextState;
      cnt    <= nextCnt;
      bitIdx <= nextBit;
      if (tick) prevRx <= rxSync;
    end
  end

endmodule

// File: rtl/uartRxDatapath.sv
module uartRxDatapath
  import uartRxPkg::*;
#(
  parameter int FIFO_DEPTH  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  parameter int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxd,
  input  rxStrobe_t         strobe,
  input  logic [2:0]        bitIdx,
  input  parMode_e          parMode,
  input  logic              readStrobe,
  input  logic              clearErr,
  input  logic              rtsSet,
  output logic              rxSync,
  output logic              dataNonZero,
  output logic              charAllLow,
  output logic [CHAR_W-1:0] rxData,
  output logic              rxReady,
  output logic              fifoFull,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakFlag,
  output logic              overrunFlag,
  output logic              rtsOut
);

  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FIFO_DEPTH - 1);

  // ---------------- line synchronizer ----------------
  logic [SYNC_STAGES-1:0] syncQ;
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b1;
        else       syncQ[s] <= rxd;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b1;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end
  assign rxSync = syncQ[SYNC_STAGES-1];

  // ---------------- character assembly ----------------
  logic [CHAR_W-1:0] charReg;
  logic              parBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      charReg <= '0;
      parBit  <= 1'b0;
    end else begin
      if (strobe.clearChar) begin
        charReg <= '0;
        parBit  <= 1'b0;
      end else begin
        if (strobe.sampleData)   charReg[bitIdx] <= rxSync;
        if (strobe.sampleParity) parBit          <= rxSync;
      end
    end
  end

  assign dataNonZero = |charReg;
  assign charAllLow  = !(|charReg) && !parBit;

  logic onesOdd;
  logic parMismatch;
  assign onesOdd = ^charReg;

  always_comb begin
    unique case (parMode)
      PAR_EVEN: parMismatch = onesOdd ^ parBit;
      PAR_ODD:  parMismatch = ~(onesOdd ^ parBit);
      PAR_ZERO: parMismatch = parBit;
      PAR_ONE:  parMismatch = ~parBit;
      default:  parMismatch = 1'b0;
    endcase
  end

  rxEntry_t newEntry;
  always_comb begin
    newEntry.data   = strobe.markBreak ? '0 : charReg;
    newEntry.parErr = strobe.markBreak ? 1'b0 : parMismatch;
    newEntry.frmErr = strobe.markFrame;
    newEntry.brk    = strobe.markBreak;
  end

  // ---------------- holding queue ----------------
  rxEntry_t         mem [FIFO_DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [LVL_W-1:0] level;
  logic             popEn, acceptEn, overrunEv;

  assign popEn     = readStrobe && (level != '0);
  assign acceptEn  = strobe.pushChar && ((level != LVL_FULL) || popEn);
  assign overrunEv = strobe.pushChar && !acceptEn;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < FIFO_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    mem[g] <= '0;
      else if (acceptEn && (wrPtr == PTR_W'(g)))    mem[g] <= newEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (popEn)    rdPtr <= ptrInc(rdPtr);
      if (acceptEn) wrPtr <= ptrInc(wrPtr);
      unique case ({acceptEn, popEn})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  rxEntry_t head;
  assign head      = mem[rdPtr];
  assign rxData    = head.data;
  assign parityErr = head.parErr;
  assign frameErr  = head.frmErr;
  assign breakFlag = head.brk;
  assign rxReady   = (level != '0);
  assign fifoFull  = (level == LVL_FULL);

  // ---------------- overrun and request-to-send ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrunFlag <= 1'b0;
      rtsOut      <= 1'b0;
    end else begin
      if (overrunEv)     overrunFlag <= 1'b1;
      else if (clearErr) overrunFlag <= 1'b0;
      if (overrunEv)     rtsOut <= 1'b0;
      else if (rtsSet)   rtsOut <= 1'b1;
    end
  end

endmodule

// File: rtl/uartRx.sv
module uartRx
  import uartRxPkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int FIFO_DEPTH  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] charLen,
  input  logic [2:0] parMode,
  input  logic       readStrobe,
  input  logic       clearErr,
  input  logic       rtsSet,
  output logic [7:0] rxData,
  output logic       rxReady,
  output logic       fifoFull,
  output logic       parityErr,
  output logic       frameErr,
  output logic       breakFlag,
  output logic       overrunFlag,
  output logic       rtsOut
);

  rxStrobe_t  strobe;
  logic [2:0] bitIdx;
  logic       rxSync, dataNonZero, charAllLow, parEnable;
  parMode_e   modeSel;

  assign parEnable = (parMode >= 3'd1) && (parMode <= 3'd4);
  assign modeSel   = parEnable ? parMode_e'(parMode) : PAR_NONE;

  uartRxCtrl #(
    .OVERSAMPLE(OVERSAMPLE)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick16),
    .rxSync     (rxSync),
    .charLen    (charLen),
    .parEnable  (parEnable),
    .dataNonZero(dataNonZero),
    .charAllLow (charAllLow),
    .strobe     (strobe),
    .bitIdx     (bitIdx)
  );

  uartRxDatapath #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxd        (rxd),
    .strobe     (strobe),
    .bitIdx     (bitIdx),
    .parMode    (modeSel),
    .readStrobe (readStrobe),
    .clearErr   (clearErr),
    .rtsSet     (rtsSet),
    .rxSync     (rxSync),
    .dataNonZero(dataNonZero),
    .charAllLow (charAllLow),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .fifoFull   (fifoFull),
    .parityErr  (parityErr),
    .frameErr   (frameErr),
    .breakFlag  (breakFlag),
    .overrunFlag(overrunFlag),
    .rtsOut     (rtsOut)
  );

endmodule

// File: rtl/uartRxChecker.sv
module uartRxChecker (
  input logic       clk,
  input logic       rstN,
  input logic       readStrobe,
  input logic       clearErr,
  input logic       rtsSet,
  input logic [7:0] rxData,
  input logic       rxReady,
  input logic       fifoFull,
  input logic       parityErr,
  input logic       frameErr,
  input logic       breakFlag,
  input logic       overrunFlag,
  input logic       rtsOut
);

  // R7: a full queue is never empty
  p_full_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> rxReady);

  // R6: a break entry holds a zero character
  p_break_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && breakFlag) |-> (rxData == 8'h00));

  // R6: a break entry carries no parity or framing error
  p_break_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && breakFlag) |-> (!parityErr && !frameErr));

  // R8: overrun stays set until cleared
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overrunFlag && !clearErr) |=> overrunFlag);

  // R9: request-to-send is low in the cycle an overrun appears
  p_ovr_drops_rts_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> !rtsOut);

  // R9: request-to-send only rises after a command
  p_rts_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rtsOut) |-> $past(rtsSet));

endmodule

bind uartRx uartRxChecker i_uartRxChecker (
  .clk        (clk),
  .rstN       (rstN),
  .readStrobe (readStrobe),
  .clearErr   (clearErr),
  .rtsSet     (rtsSet),
  .rxData     (rxData),
  .rxReady    (rxReady),
  .fifoFull   (fifoFull),
  .parityErr  (parityErr),
  .frameErr   (frameErr),
  .breakFlag  (breakFlag),
  .overrunFlag(overrunFlag),
  .rtsOut     (rtsOut)
);

// File: tb/test_uartRx.sv
module test_uartRx;

  localparam int CLK_PERIOD = 10;
  localparam int BIT        = 16;   // tick16 held high: sixteen clocks per bit
  localparam int QDEPTH     = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] charLen = 2'd3;
  logic [2:0] parMode = 3'd0;
  logic       readStrobe = 1'b0;
  logic       clearErr = 1'b0;
  logic       rtsSet = 1'b0;
  logic [7:0] rxData;
  logic       rxReady, fifoFull, parityErr, frameErr, breakFlag, overrunFlag, rtsOut;

  uartRx i_uartRx (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxd(rxd),
    .charLen(charLen), .parMode(parMode),
    .readStrobe(readStrobe), .clearErr(clearErr), .rtsSet(rtsSet),
    .rxData(rxData), .rxReady(rxReady), .fifoFull(fifoFull),
    .parityErr(parityErr), .frameErr(frameErr), .breakFlag(breakFlag),
    .overrunFlag(overrunFlag), .rtsOut(rtsOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit settled = 0;

  typedef struct {
    logic [7:0] d;
    bit pe;
    bit fe;
    bit brk;
  } exp_t;

  exp_t q[$];
  bit mOvr = 0;
  bit mRts = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model compared on every clock while the line is between frames
  always @(negedge clk) begin
    if (rstN && settled && !done) begin
      check(rxReady == (q.size() != 0), "R7 ready", rxReady, q.size() != 0);
      check(fifoFull == (q.size() == QDEPTH), "R7 full", fifoFull, q.size() == QDEPTH);
      check(overrunFlag == mOvr, "R8 overrun", overrunFlag, mOvr);
      check(rtsOut == mRts, "R9 rts", rtsOut, mRts);
      if (q.size() != 0) begin
        check(rxData == q[0].d, "R2 data", rxData, q[0].d);
        check(parityErr == q[0].pe, "R3 parity", parityErr, q[0].pe);
        check(frameErr == q[0].fe, "R5 frame", frameErr, q[0].fe);
        check(breakFlag == q[0].brk, "R6 break", breakFlag, q[0].brk);
      end
    end
  end

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic modelPush(input exp_t e);
    if (q.size() == QDEPTH) begin
      mOvr = 1;
      mRts = 0;
    end else begin
      q.push_back(e);
    end
  endtask

  function automatic bit goodPar(input logic [7:0] d, input int len, input logic [2:0] pm);
    bit ones = 0;
    for (int i = 0; i < len; i++) ones ^= d[i];
    case (pm)
      3'd1: return ones;
      3'd2: return !ones;
      3'd3: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // one framed character; stopLow gives a short low stop bit followed by idle
  task automatic sendChar(input logic [7:0] d, input bit badPar, input bit stopLow);
    int len = 5 + int'(charLen);
    logic [7:0] masked = d & 8'((1 << len) - 1);
    exp_t e;
    settled = 0;
    hold(1'b0, BIT);
    for (int i = 0; i < len; i++) hold(d[i], BIT);
    if (parMode != 3'd0) hold(goodPar(d, len, parMode) ^ badPar, BIT);
    if (stopLow) begin
      hold(1'b0, 13);
      hold(1'b1, 3);
    end else begin
      hold(1'b1, BIT);
    end
    e.d = masked;
    e.pe = (parMode != 3'd0) && badPar;
    e.fe = stopLow;
    e.brk = 0;
    modelPush(e);
    settled = 1;
  endtask

  task automatic doRead();
    readStrobe = 1;
    @(posedge clk); #1;
    readStrobe = 0;
    if (q.size() != 0) void'(q.pop_front());
  endtask

  task automatic doClear();
    clearErr = 1;
    @(posedge clk); #1;
    clearErr = 0;
    mOvr = 0;
  endtask

  task automatic doRts();
    rtsSet = 1;
    @(posedge clk); #1;
    rtsSet = 0;
    mRts = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exp_t e;
    logic [7:0] a, b;
    repeat (4) @(posedge clk); #1;
    rstN = 1;
    @(posedge clk); #1;
    // R10 reset state
    check(!rxReady && !fifoFull, "R10 queue empty", {rxReady, fifoFull}, 0);
    check(!overrunFlag && !rtsOut, "R10 flags low", {overrunFlag, rtsOut}, 0);
    settled = 1;
    hold(1'b1, 20);

    // R1 short low pulse is not a start bit
    hold(1'b0, 4);
    hold(1'b1, 60);
    check(!rxReady, "R1 glitch rejected", rxReady, 0);

    // R2 eight bits, LSB first
    sendChar(8'hA5, 0, 0);
    hold(1'b1, 8);
    check(rxData == 8'hA5, "R2 8-bit char", rxData, 8'hA5);
    doRead();
    check(!rxReady, "R7 read empties", rxReady, 0);

    // R2 five bits, upper bits zero
    charLen = 2'd0;
    sendChar(8'hF5, 0, 0);
    hold(1'b1, 8);
    check(rxData == 8'h15, "R2 5-bit upper zero", rxData, 8'h15);
    doRead();
    charLen = 2'd2;
    sendChar(8'hFF, 0, 0);
    hold(1'b1, 8);
    check(rxData == 8'h7F, "R2 7-bit upper zero", rxData, 8'h7F);
    doRead();

    // R3 parity modes
    charLen = 2'd3;
    parMode = 3'd1; sendChar(8'h37, 0, 0); hold(1'b1, 8);
    check(!parityErr, "R3 even ok", parityErr, 0); doRead();
    parMode = 3'd1; sendChar(8'h37, 1, 0); hold(1'b1, 8);
    check(parityErr, "R3 even bad", parityErr, 1); doRead();
    parMode = 3'd2; sendChar(8'h80, 1, 0); hold(1'b1, 8);
    check(parityErr, "R3 odd bad", parityErr, 1); doRead();
    parMode = 3'd2; sendChar(8'h81, 0, 0); hold(1'b1, 8);
    check(!parityErr, "R3 odd ok", parityErr, 0); doRead();
    parMode = 3'd3; sendChar(8'h5A, 1, 0); hold(1'b1, 8);
    check(parityErr, "R3 forced zero mismatch", parityErr, 1); doRead();
    parMode = 3'd4; sendChar(8'h5A, 0, 0); hold(1'b1, 8);
    check(!parityErr, "R3 forced one match", parityErr, 0); doRead();
    parMode = 3'd0;

    // R4 back-to-back characters with no idle gap
    sendChar(8'h11, 0, 0);
    sendChar(8'hEE, 0, 0);
    hold(1'b1, 8);
    check(rxData == 8'h11, "R4 first of pair", rxData, 8'h11);
    doRead();
    check(rxData == 8'hEE && rxReady, "R4 second of pair", rxData, 8'hEE);
    doRead();

    // R5 framing error, line returns high
    sendChar(8'h55, 0, 1);
    hold(1'b1, 40);
    check(frameErr && rxData == 8'h55, "R5 frame error stored", {frameErr, rxData}, {1'b1, 8'h55});
    doRead();
    check(!rxReady, "R5 no extra char after high", rxReady, 0);

    // R5 framing error followed by low line: restart without edge
    a = 8'h41; b = 8'h3C;
    settled = 0;
    hold(1'b0, BIT);
    for (int i = 0; i < 8; i++) hold(a[i], BIT);
    hold(1'b0, BIT + BIT/2);
    for (int i = 0; i < 8; i++) hold(b[i], BIT);
    hold(1'b1, BIT);
    e.d = a; e.pe = 0; e.fe = 1; e.brk = 0; modelPush(e);
    e.d = b; e.pe = 0; e.fe = 0; e.brk = 0; modelPush(e);
    settled = 1;
    hold(1'b1, 8);
    check(frameErr && rxData == 8'h41, "R5 restart first", rxData, 8'h41);
    doRead();
    check(!frameErr && rxData == 8'h3C, "R5 restart second", rxData, 8'h3C);
    doRead();

    // R6 break then short high that must not reopen the start search
    settled = 0;
    hold(1'b0, BIT * 10);
    e.d = 8'h00; e.pe = 0; e.fe = 0; e.brk = 1; modelPush(e);
    settled = 1;
    hold(1'b0, 20);
    hold(1'b1, 4);
    hold(1'b0, 30);
    hold(1'b1, 40);
    check(breakFlag && rxData == 8'h00, "R6 break stored", {breakFlag, rxData}, 9'h100);
    doRead();
    check(!rxReady, "R6 no start during break", rxReady, 0);
    sendChar(8'h6B, 0, 0);
    hold(1'b1, 8);
    check(rxData == 8'h6B && !breakFlag, "R6 recovery", rxData, 8'h6B);
    doRead();

    // R7 read on empty queue has no effect
    doRead();
    check(!rxReady && !fifoFull, "R7 empty read ignored", {rxReady, fifoFull}, 0);

    // R9 software raises RTS
    doRts();
    check(rtsOut, "R9 rts set", rtsOut, 1);

    // R7/R8 fill queue then overrun
    sendChar(8'hC1, 0, 0);
    sendChar(8'hC2, 0, 0);
    sendChar(8'hC3, 0, 0);
    hold(1'b1, 8);
    check(fifoFull, "R7 full at three", fifoFull, 1);
    check(rtsOut, "R9 rts held", rtsOut, 1);
    sendChar(8'hC4, 0, 0);
    hold(1'b1, 8);
    check(overrunFlag, "R8 overrun set", overrunFlag, 1);
    check(!rtsOut, "R9 rts dropped on overrun", rtsOut, 0);
    check(rxData == 8'hC1, "R8 oldest kept", rxData, 8'hC1);
    hold(1'b1, 20);
    check(overrunFlag, "R8 overrun sticky", overrunFlag, 1);
    doClear();
    check(!overrunFlag, "R8 overrun cleared", overrunFlag, 0);
    check(rxData == 8'hC1, "R7 order 1", rxData, 8'hC1); doRead();
    check(rxData == 8'hC2, "R7 order 2", rxData, 8'hC2); doRead();
    check(rxData == 8'hC3, "R7 order 3", rxData, 8'hC3); doRead();
    check(!rxReady, "R8 dropped char absent", rxReady, 0);
    doRts();
    check(rtsOut, "R9 rts reasserted", rtsOut, 1);

    hold(1'b1, 20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule